// File: doc/BRIEF.md
# Adaptive Reference and Soft-Start Controller

This block produces the 8-bit pulse width for a digitally controlled buck converter that regulates a supply to the minimum level a delay-line monitor will accept. It keeps an accumulated reference level. On each PWM load pulse, that level moves by up to three counts. The size and direction of the move come from six tap flags. Each flag shows whether a clock edge launched into the delay line reached that tap within the sampling window. The reference is added to an externally supplied frequency-compensated word to form a normal width. An output selector can then double or halve that width, which speeds the supply up or calms it down while it moves fast.

A 3-bit state machine sequences the loop. The lower four states bring the supply up from reset in steps that get smaller. The upper four states track the target and hold it. When the clock frequency drops, the upper states also hunt downward for the lowest reference code that still meets timing. This hunt is needed because several fine codes can land in the same coarse delay bin. A counter-clear output tells the downstream PWM counter when the machine is in its idle start state.

Top module: `avs_ref_ctrl`

## Requirements
- R1: A synchronous active-high reset puts the state at 000, the reference and the pulse width at 0, and both voltage flags at 0.
- R2: State, reference, pulse width and flags change only on a clock edge where `load` is 1.
- R3: Soft start runs as follows, and the frequency indicators are ignored throughout it:
  - 000 moves to 001 unconditionally.
  - 001 adds 3 with the doubled width until the first tap is reached, then moves to 010 without a step.
  - 010 adds 2 until the prior tap is reached, then moves to 011.
  - 011 adds 1 until the centre tap is reached, then moves to 100.
- R4: In state 100 the first matching rule applies:
  - First tap not reached: +3, doubled width.
  - Last tap reached: -3, halved width.
  - Prior tap not reached: +2.
  - Centre tap not reached: +1.
  - Next-next tap reached: -2.
  - Next tap reached: -1.
  - Otherwise (on target): no step, and the state moves to 101.
- R5: The pulse width registered on a load is the new reference plus `fcw`, saturated to 8 bits. Under the selector it is then shifted left one place (saturated) or right one place (floor).
- R6: The reference saturates at 0 and 255, and the pulse width saturates at 255.
- R7: States 101 and 111 step nothing. A frequency-up indicator takes priority and moves to 100. Otherwise a frequency-down indicator moves to 110. Otherwise a reading off target (centre tap not reached, or next tap reached) moves to 100.
- R8: State 110 subtracts 1 per load while the centre tap is reached. Once the centre tap is lost, it adds 1 back and moves to 111. The frequency indicators are ignored in 110.
- R9: On a load in states 1xx, `low_flag` is set when the first tap is not reached. On such a load, `high_flag` is set when the first and last taps are both reached. Both flags clear on a load in states 0xx.
- R10: `clr_cnt` is 1 exactly while the state is 000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load | input | 1 | PWM load pulse; update strobe |
| fcw | input | 8 | Frequency-compensated width word |
| tap_first | input | 1 | First tap reached |
| tap_prior | input | 1 | Tap before centre reached |
| tap_centre | input | 1 | Centre tap reached |
| tap_next | input | 1 | Tap after centre reached |
| tap_next2 | input | 1 | Second tap after centre reached |
| tap_last | input | 1 | Last tap reached |
| freq_up | input | 1 | Frequency raised indicator |
| freq_dn | input | 1 | Frequency lowered indicator |
| state | output | 3 | Current controller state |
| ref_level | output | 8 | Accumulated reference |
| pw | output | 8 | Registered pulse width |
| low_flag | output | 1 | Supply below window |
| high_flag | output | 1 | Supply above window |
| clr_cnt | output | 1 | Clear for the PWM counter |

## Verification
Two situations can arrive on the same load pulse.

In the hold state, both frequency indicators can be raised together. The bench provokes this with equal taps and expects the raise request to win, sending the state back to tracking.

In the downward hunt, the load that backs the reference up by one code can coincide with a frequency-up request. The bench raises `freq_up` on exactly that load. It judges the result by requiring the reference to rise by one and the state to reach 111, rather than going to tracking.

// File: rtl/avs_ref_pkg.sv
package avs_ref_pkg;

  typedef enum logic [2:0] {
    ST_START   = 3'd0,
    ST_FAST    = 3'd1,
    ST_MID     = 3'd2,
    ST_FINE    = 3'd3,
    ST_TRACK   = 3'd4,
    ST_HOLD    = 3'd5,
    ST_HUNT    = 3'd6,
    ST_SETTLED = 3'd7
  } avs_state_e;

  typedef enum logic [1:0] {
    SEL_NORM = 2'd0,
    SEL_DBL  = 2'd1,
    SEL_HALF = 2'd2
  } width_sel_e;

  typedef struct packed {
    logic first;
    logic prior;
    logic centre;
    logic next;
    logic next2;
    logic last;
  } tap_flags_t;

endpackage

// File: rtl/avs_ctrl_fsm.sv
module avs_ctrl_fsm
  import avs_ref_pkg::*;
#(
  parameter int STEP_W = 3
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     load,
  input  tap_flags_t               taps,
  input  logic                     freq_up,
  input  logic                     freq_dn,
  output avs_state_e               state_q,
  output logic signed [STEP_W-1:0] step,
  output width_sel_e               sel,
  output logic                     low_q,
  output logic                     high_q
);

  localparam logic signed [STEP_W-1:0] STEP1 = STEP_W'(1);
  localparam logic signed [STEP_W-1:0] STEP2 = STEP_W'(2);
  localparam logic signed [STEP_W-1:0] STEP3 = STEP_W'(3);

  avs_state_e nxt;
  logic       on_target;
  logic       regulating;

  assign on_target  = taps.centre && !taps.next;
  assign regulating = state_q[2];

  always_comb begin
    nxt  = state_q;
    step = '0;
    sel  = SEL_NORM;
    case (state_q)
      ST_START: nxt = ST_FAST;
      ST_FAST:
        if (taps.first) nxt = ST_MID;
        else begin
          step = STEP3;
          sel  = SEL_DBL;
        end
      ST_MID:
        if (taps.prior) nxt = ST_FINE;
        else step = STEP2;
      ST_FINE:
        if (taps.centre) nxt = ST_TRACK;
        else step = STEP1;
      ST_TRACK:
        if (!taps.first) begin
          step = STEP3;
          sel  = SEL_DBL;
        end else if (taps.last) begin
          step = -STEP3;
          sel  = SEL_HALF;
        end else if (!taps.prior)  step = STEP2;
        else if (!taps.centre)     step = STEP1;
        else if (taps.next2)       step = -STEP2;
        else if (taps.next)        step = -STEP1;
        else                       nxt  = ST_HOLD;
      ST_HOLD, ST_SETTLED:
        if (freq_up)         nxt = ST_TRACK;
        else if (freq_dn)    nxt = ST_HUNT;
        else if (!on_target) nxt = ST_TRACK;
      ST_HUNT:
        if (taps.centre) step = -STEP1;
        else begin
          step = STEP1;
          nxt  = ST_SETTLED;
        end
      default: nxt = ST_START;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_START;
      low_q   <= 1'b0;
      high_q  <= 1'b0;
    end else if (load) begin
      state_q <= nxt;
      low_q   <= regulating && !taps.first;
      high_q  <= regulating && taps.first && taps.last;
    end
  end

endmodule

// File: rtl/avs_ref_accum.sv
module avs_ref_accum #(
  parameter int W      = 8,
  parameter int STEP_W = 3
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     load,
  input  logic signed [STEP_W-1:0] step,
  output logic        [W-1:0]      ref_q,
  output logic        [W-1:0]      ref_nxt
);

  localparam int SUM_W = W + 2;
  localparam int MAXV  = (1 << W) - 1;

  logic signed [SUM_W-1:0] sum;

  always_comb begin
    sum = $signed({2'b00, ref_q}) +
          $signed({{(SUM_W-STEP_W){step[STEP_W-1]}}, step});
    if (sum < 0)         ref_nxt = '0;
    else if (sum > MAXV) ref_nxt = '1;
    else                 ref_nxt = sum[W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst)       ref_q <= '0;
    else if (load) ref_q <= ref_nxt;
  end

endmodule

// File: rtl/avs_width_sel.sv
module avs_width_sel
  import avs_ref_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] fcw,
  input  logic [W-1:0] ref_nxt,
  input  width_sel_e   sel,
  output logic [W-1:0] pw_q
);

  logic [W:0]   sum_w;
  logic [W-1:0] npw;
  logic [W:0]   dbl_w;
  logic [W-1:0] pw_nxt;

  always_comb begin
    sum_w = {1'b0, fcw} + {1'b0, ref_nxt};
    npw   = sum_w[W] ? '1 : sum_w[W-1:0];
    dbl_w = {npw, 1'b0};
    case (sel)
      SEL_DBL:  pw_nxt = dbl_w[W] ? '1 : dbl_w[W-1:0];
      SEL_HALF: pw_nxt = npw >> 1;
      default:  pw_nxt = npw;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)       pw_q <= '0;
    else if (load) pw_q <= pw_nxt;
  end

endmodule

// File: rtl/avs_ref_ctrl.sv
module avs_ref_ctrl
  import avs_ref_pkg::*;
#(
  parameter int W      = 8,
  parameter int STEP_W = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] fcw,
  input  logic         tap_first,
  input  logic         tap_prior,
  input  logic         tap_centre,
  input  logic         tap_next,
  input  logic         tap_next2,
  input  logic         tap_last,
  input  logic         freq_up,
  input  logic         freq_dn,
  output logic [2:0]   state,
  output logic [W-1:0] ref_level,
  output logic [W-1:0] pw,
  output logic         low_flag,
  output logic         high_flag,
  output logic         clr_cnt
);

  tap_flags_t               taps;
  avs_state_e               st;
  logic signed [STEP_W-1:0] step;
  width_sel_e               sel;
  logic [W-1:0]             ref_nxt;

  assign taps = '{first: tap_first, prior: tap_prior, centre: tap_centre,
                  next: tap_next, next2: tap_next2, last: tap_last};

  avs_ctrl_fsm #(.STEP_W(STEP_W)) u_fsm (
    .clk(clk), .rst(rst), .load(load), .taps(taps),
    .freq_up(freq_up), .freq_dn(freq_dn),
    .state_q(st), .step(step), .sel(sel),
    .low_q(low_flag), .high_q(high_flag)
  );

  avs_ref_accum #(.W(W), .STEP_W(STEP_W)) u_acc (
    .clk(clk), .rst(rst), .load(load), .step(step),
    .ref_q(ref_level), .ref_nxt(ref_nxt)
  );

  avs_width_sel #(.W(W)) u_sel (
    .clk(clk), .rst(rst), .load(load), .fcw(fcw),
    .ref_nxt(ref_nxt), .sel(sel), .pw_q(pw)
  );

  assign state   = st;
  assign clr_cnt = (st == ST_START);

endmodule

// File: rtl/avs_ref_ctrl_chk.sv
module avs_ref_ctrl_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         load,
  input logic         tap_first,
  input logic         tap_centre,
  input logic [2:0]   state,
  input logic [W-1:0] ref_level,
  input logic [W-1:0] pw,
  input logic         low_flag,
  input logic         high_flag
);

  assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (state == 3'd0 && ref_level == '0 && pw == '0));

  assert_hold_no_load_R2: assert property (@(posedge clk) disable iff (rst)
    !load |=> ($stable(state) && $stable(ref_level) && $stable(pw)));

  assert_start_to_fast_R3: assert property (@(posedge clk) disable iff (rst)
    (load && state == 3'd0) |=> state == 3'd1);

  assert_step_bound_R4: assert property (@(posedge clk) disable iff (rst)
    load |=> ((ref_level >= $past(ref_level) ? ref_level - $past(ref_level)
                                              : $past(ref_level) - ref_level) <= 3));

  assert_hunt_backup_R8: assert property (@(posedge clk) disable iff (rst)
    (load && state == 3'd6 && !tap_centre) |=>
      (state == 3'd7 && (ref_level == $past(ref_level) + 1'b1 || $past(ref_level) == '1)));

  assert_low_flag_R9: assert property (@(posedge clk) disable iff (rst)
    (load && state[2] && !tap_first) |=> low_flag);

  assert_flags_excl_R9: assert property (@(posedge clk) disable iff (rst)
    !(low_flag && high_flag));

endmodule

bind avs_ref_ctrl avs_ref_ctrl_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .load(load), .tap_first(tap_first),
  .tap_centre(tap_centre), .state(state), .ref_level(ref_level),
  .pw(pw), .low_flag(low_flag), .high_flag(high_flag)
);

// File: tb/tb_avs_ref_ctrl.sv
`timescale 1ns/1ps
module tb_avs_ref_ctrl;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic load = 1'b0;
  logic [7:0] fcw = 8'd40;
  logic [5:0] taps = 6'b0;  // {first, prior, centre, next, next2, last}
  logic fup = 1'b0, fdn = 1'b0;
  logic [2:0] state;
  logic [7:0] ref_level, pw;
  logic low_flag, high_flag, clr_cnt;
  int errors = 0, checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  avs_ref_ctrl dut (
    .clk(clk), .rst(rst), .load(load), .fcw(fcw),
    .tap_first(taps[5]), .tap_prior(taps[4]), .tap_centre(taps[3]),
    .tap_next(taps[2]), .tap_next2(taps[1]), .tap_last(taps[0]),
    .freq_up(fup), .freq_dn(fdn),
    .state(state), .ref_level(ref_level), .pw(pw),
    .low_flag(low_flag), .high_flag(high_flag), .clr_cnt(clr_cnt)
  );

  // row: {taps[6], fup, fdn, state[3], ref[8], pw[8], low, high}, fcw = 40
  localparam logic [28:0] VEC [20] = '{
    {6'b000000, 2'b00, 3'd1, 8'd0, 8'd40, 2'b00},
    {6'b000000, 2'b00, 3'd1, 8'd3, 8'd86, 2'b00},
    {6'b000000, 2'b00, 3'd1, 8'd6, 8'd92, 2'b00},
    {6'b100000, 2'b00, 3'd2, 8'd6, 8'd46, 2'b00},
    {6'b100000, 2'b00, 3'd2, 8'd8, 8'd48, 2'b00},
    {6'b110000, 2'b00, 3'd3, 8'd8, 8'd48, 2'b00},
    {6'b110000, 2'b00, 3'd3, 8'd9, 8'd49, 2'b00},
    {6'b111000, 2'b00, 3'd4, 8'd9, 8'd49, 2'b00},
    {6'b111110, 2'b00, 3'd4, 8'd7, 8'd47, 2'b00},
    {6'b111100, 2'b00, 3'd4, 8'd6, 8'd46, 2'b00},
    {6'b111000, 2'b00, 3'd5, 8'd6, 8'd46, 2'b00},
    {6'b111000, 2'b01, 3'd6, 8'd6, 8'd46, 2'b00},
    {6'b111000, 2'b00, 3'd6, 8'd5, 8'd45, 2'b00},
    {6'b111000, 2'b00, 3'd6, 8'd4, 8'd44, 2'b00},
    {6'b110000, 2'b00, 3'd7, 8'd5, 8'd45, 2'b00},
    {6'b110000, 2'b00, 3'd4, 8'd5, 8'd45, 2'b00},
    {6'b000000, 2'b00, 3'd4, 8'd8, 8'd96, 2'b10},
    {6'b111111, 2'b00, 3'd4, 8'd5, 8'd22, 2'b01},
    {6'b111000, 2'b00, 3'd5, 8'd5, 8'd45, 2'b00},
    {6'b111000, 2'b10, 3'd4, 8'd5, 8'd45, 2'b00}
  };

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic do_load(input logic [5:0] t, input logic u, input logic d);
    @(negedge clk);
    taps = t; fup = u; fdn = d; load = 1'b1;
    @(negedge clk);
    load = 1'b0; fup = 1'b0; fdn = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic expect3(input string req, input int s, input int r, input int p);
    chk(req, "state", int'(state), s);
    chk(req, "ref", int'(ref_level), r);
    chk("R5", "pw", int'(pw), p);
  endtask

  function automatic string req_of(input int s);
    if (s < 4)      return "R3";
    else if (s == 4) return "R4";
    else if (s == 6) return "R8";
    else            return "R7";
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 / R10: reset state
    expect3("R1", 0, 0, 0);
    chk("R1", "low", int'(low_flag), 0);
    chk("R1", "high", int'(high_flag), 0);
    chk("R10", "clr in 000", int'(clr_cnt), 1);

    for (int i = 0; i < 20; i++) begin
      logic [28:0] v;
      v = VEC[i];
      do_load(v[28:23], v[22], v[21]);
      expect3(req_of(int'(v[20:18])), int'(v[20:18]), int'(v[17:10]), int'(v[9:2]));
      chk("R9", "low", int'(low_flag), int'(v[1]));
      chk("R9", "high", int'(high_flag), int'(v[0]));
    end

    // R2: inputs move without load, nothing changes
    taps = 6'b000000; fup = 1'b1;
    repeat (5) @(negedge clk);
    fup = 1'b0;
    expect3("R2", 4, 5, 45);
    chk("R2", "low", int'(low_flag), 0);

    // R1 / R10: reset mid-run, then leave 000
    do_reset();
    expect3("R1", 0, 0, 0);
    chk("R10", "clr in 000", int'(clr_cnt), 1);
    do_load(6'b000000, 1'b0, 1'b0);
    chk("R10", "clr after 000", int'(clr_cnt), 0);
    expect3("R3", 1, 0, 40);
    // R3: frequency indicators ignored during soft start
    do_load(6'b000000, 1'b1, 1'b1);
    expect3("R3", 1, 3, 86);

    // R6: lower saturation of the reference
    do_load(6'b100000, 1'b0, 1'b0);
    do_load(6'b110000, 1'b0, 1'b0);
    do_load(6'b111000, 1'b0, 1'b0);
    expect3("R3", 4, 3, 43);
    do_load(6'b111110, 1'b0, 1'b0);
    expect3("R4", 4, 1, 41);
    do_load(6'b111110, 1'b0, 1'b0);
    expect3("R6", 4, 0, 40);

    // R7: both frequency indicators in hold, raise wins
    do_load(6'b111000, 1'b0, 1'b0);
    chk("R7", "state", int'(state), 5);
    do_load(6'b111000, 1'b1, 1'b1);
    chk("R7", "up priority", int'(state), 4);

    // R8: hunt back-up step together with a frequency raise
    for (int k = 0; k < 4; k++) do_load(6'b110000, 1'b0, 1'b0);
    expect3("R4", 4, 4, 44);
    do_load(6'b111000, 1'b0, 1'b0);
    do_load(6'b111000, 1'b0, 1'b1);
    expect3("R8", 6, 4, 44);
    do_load(6'b111000, 1'b0, 1'b0);
    expect3("R8", 6, 3, 43);
    do_load(6'b110000, 1'b1, 1'b0);
    expect3("R8", 7, 4, 44);

    // R6: upper saturation of reference and pulse width
    do_reset();
    fcw = 8'd0;
    do_load(6'b000000, 1'b0, 1'b0);
    for (int k = 0; k < 90; k++) do_load(6'b000000, 1'b0, 1'b0);
    expect3("R6", 1, 255, 255);
    fcw = 8'd200;
    do_load(6'b100000, 1'b0, 1'b0);
    expect3("R6", 2, 255, 255);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule